// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog Timer

This block is a 32-bit watchdog timer that sits on a simple single-cycle register bus. Software sets a reload value and turns the timer on, which loads the down-counter. The count then falls by one on every cycle of a tick-enable input. To keep the system alive, software must write a fixed 16-bit key into a restart register before the count runs out.

If the count does reach zero, a sticky expiry flag is set in the status register. Control bits decide what follows. A level interrupt can be raised. A system reset request pulse can be sent. An external signal pulse can also be sent. Both pulses have a width, counted in clock cycles, that is set by a programmable length register. The status flag is cleared by writing ones to a separate clear register.

Top module: `wdog_top`

## Requirements
- R1: After synchronous reset: control reads 0, status reads 0, load reads 0x03EF1480, pulse length reads 0x000000FF, and the interrupt, reset-request and external outputs are low.
- R2: Register offsets:
  - 0x04: load (32-bit read/write).
  - 0x0C: control, bits [4:0] read/write; bit0 run, bit1 reset-request enable, bit2 interrupt enable, bit3 external enable, bit4 clock select (stored only); upper bits read 0.
  - 0x18: pulse length, low 8 bits read/write.
  - 0x1C: revision, reads 0x00010601.
  - 0x08 (restart) and 0x14 (clear) read 0.
- R3: An offset of 0x20 or above, or one that is not a multiple of 4, reads 0. Writes to such offsets change no register.
- R4: Offset 0x00 returns the load register while bit0 of control is 0, and the live count while it is 1.
- R5: A control write with bit0=1 while the timer is stopped loads the count from the load register. While running, each cycle with tick-enable high lowers the count by one.
- R6: A control write with bit0=1 while already running leaves the count unchanged. A write with bit0=0 stops the timer, and ticks then have no effect.
- R7: While running, writing exactly 0x00005AB9 to offset 0x08 reloads the count from the load register. Any other value written there leaves the count unchanged.
- R8: Expiry happens on the tick that takes the count from 1 to 0, or on the first tick after a load of 0. Expiry sets status bit1 (status reads 0x2). The count then stays at 0, and no further expiry occurs until a reload.
- R9: Writing offset 0x14 clears each status bit whose written bit is 1. Written zero bits leave status unchanged.
- R10: The interrupt output is high exactly while status bit1 and control bit2 are both 1.
- R11: If control bit1 is 1 at expiry, the reset-request output goes high starting the cycle after expiry, for as many cycles as the pulse length. A length of 0 gives no pulse.
- R12: The external output behaves the same way as the reset-request output, but is gated by control bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-down tick enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| wd_irq | output | 1 | Level interrupt |
| wd_sysrst_req | output | 1 | System reset request pulse |
| wd_ext_pulse | output | 1 | External signal pulse |

## Verification
Some properties are checked by the assertions on every cycle:
- The count steps down by exactly one per tick.
- The count stays at zero once it has expired.
- The count is frozen while the timer is stopped.
- Expiry always sets the status flag.
- The status flag only drops after a matching clear write.
- Each pulse begins the cycle after its trigger.

Other behaviour can only be shown by the bench's scenarios:
- Where expiry falls for small load values, including zero.
- Pulse widths across several lengths and every combination of enable bits.
- Rejection of wrong restart keys.
- No reload when the timer is enabled a second time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        IDX_COUNT   = 3'd0,
        IDX_LOAD    = 3'd1,
        IDX_RESTART = 3'd2,
        IDX_CTRL    = 3'd3,
        IDX_STATUS  = 3'd4,
        IDX_CLEAR   = 3'd5,
        IDX_PLEN    = 3'd6,
        IDX_REV     = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic clk_sel;
        logic ext_en;
        logic irq_en;
        logic rst_en;
        logic run;
    } ctrl_t;

    localparam logic [BUS_W-1:0] RESTART_KEY = 32'h0000_5AB9;
    localparam logic [BUS_W-1:0] LOAD_INIT   = 32'h03EF_1480;
    localparam logic [BUS_W-1:0] REV_VALUE   = 32'h0001_0601;
    localparam int STATUS_BIT = 1;
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic armed;

    assign fire = run && tick && armed && (cnt <= ONE) && !load_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load_req) begin
            cnt   <= load_val;
            armed <= 1'b1;
        end else if (run && tick) begin
            if (fire) begin
                cnt   <= '0;
                armed <= 1'b0;
            end else if (cnt != '0) begin
                cnt <= cnt - ONE;
            end
        end
    end

    // R5: one tick lowers the count by exactly one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load_req && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
    // R8: an expired count stays at zero until reloaded
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load_req) |=> (cnt == '0));
    // R6: a stopped timer keeps its count
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_req) |=> $stable(cnt));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (trig)
            remain <= len;
        else if (remain != '0)
            remain <= remain - LEN_W'(1);
    end

    assign pulse = (remain != '0);

    // R11: pulse begins the cycle after its trigger when length is nonzero
    p_pulse_start_r11: assert property (@(posedge clk) disable iff (rst)
        trig |=> (pulse == ($past(len) != '0)));
    // R12: with no trigger and an idle counter, no pulse appears
    p_pulse_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!trig && !pulse) |=> !pulse);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fire,
    output ctrl_t             ctrl_q,
    output logic              status_q,
    output logic [PLEN_W-1:0] plen_q,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_q
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = 4;

    logic     mapped;
    reg_idx_e idx;
    logic     wr_en;
    logic     clr_hit;
    ctrl_t    wctrl;

    assign mapped  = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:IDX_HI+1] == '0);
    assign idx     = reg_idx_e'(bus_addr[IDX_HI:IDX_LO]);
    assign wr_en   = bus_sel && bus_wr && mapped;
    assign wctrl   = ctrl_t'(bus_wdata[4:0]);
    assign clr_hit = wr_en && (idx == IDX_CLEAR) && bus_wdata[STATUS_BIT];

    always_comb begin
        load_req = 1'b0;
        if (wr_en && idx == IDX_CTRL && wctrl.run && !ctrl_q.run)
            load_req = 1'b1;
        if (wr_en && idx == IDX_RESTART && ctrl_q.run && bus_wdata == RESTART_KEY)
            load_req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= CNT_W'(LOAD_INIT);
            plen_q <= '1;
        end else if (wr_en) begin
            case (idx)
                IDX_LOAD: load_q <= bus_wdata[CNT_W-1:0];
                IDX_CTRL: ctrl_q <= wctrl;
                IDX_PLEN: plen_q <= bus_wdata[PLEN_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else if (fire)
            status_q <= 1'b1;
        else if (clr_hit)
            status_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            case (idx)
                IDX_COUNT:  bus_rdata = ctrl_q.run ? BUS_W'(cnt) : BUS_W'(load_q);
                IDX_LOAD:   bus_rdata = BUS_W'(load_q);
                IDX_CTRL:   bus_rdata = BUS_W'(ctrl_q);
                IDX_STATUS: bus_rdata = BUS_W'(status_q) << STATUS_BIT;
                IDX_PLEN:   bus_rdata = BUS_W'(plen_q);
                IDX_REV:    bus_rdata = REV_VALUE;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R8: expiry always leaves the status flag set
    p_fire_sets_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> status_q);
    // R9: status only falls after a write-one clear
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status_q && !clr_hit) |=> status_q);
    // R6: a second enable while running never reloads
    p_no_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && idx == IDX_CTRL && wr_en) |-> !load_req);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_irq,
    output logic              wd_sysrst_req,
    output logic              wd_ext_pulse
);
    localparam int N_PULSE = 2;

    ctrl_t              ctrl_q;
    logic               status_q;
    logic [PLEN_W-1:0]  plen_q;
    logic               load_req;
    logic [CNT_W-1:0]   load_q;
    logic [CNT_W-1:0]   cnt;
    logic               fire;
    logic [N_PULSE-1:0] trig;
    logic [N_PULSE-1:0] pulses;

    wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PLEN_W(PLEN_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .fire(fire),
        .ctrl_q(ctrl_q), .status_q(status_q), .plen_q(plen_q),
        .load_req(load_req), .load_q(load_q)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick_en),
        .load_req(load_req), .load_val(load_q), .cnt(cnt), .fire(fire)
    );

    assign trig = {fire && ctrl_q.ext_en, fire && ctrl_q.rst_en};

    for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
        wdog_pulse #(.LEN_W(PLEN_W)) u_pulse (
            .clk(clk), .rst(rst), .trig(trig[g]), .len(plen_q), .pulse(pulses[g])
        );
    end

    assign wd_sysrst_req = pulses[0];
    assign wd_ext_pulse  = pulses[1];
    assign wd_irq        = status_q && ctrl_q.irq_en;
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq, wd_sysrst_req, wd_ext_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_top i_wdog_top (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_sysrst_req(wd_sysrst_req), .wd_ext_pulse(wd_ext_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h0C, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h10, v); chk("R1 status", v, 32'h0);
        rd(8'h04, v); chk("R1 load", v, 32'h03EF1480);
        rd(8'h18, v); chk("R1 plen", v, 32'hFF);
        chk("R1 outputs", {29'b0, wd_irq, wd_sysrst_req, wd_ext_pulse}, 32'h0);

        // R2 register map
        rd(8'h1C, v); chk("R2 revision", v, 32'h00010601);
        wr(8'h04, 32'hDEADBEEF); rd(8'h04, v); chk("R2 load rw", v, 32'hDEADBEEF);
        wr(8'h18, 32'hABCDE123); rd(8'h18, v); chk("R2 plen rw", v, 32'h23);
        wr(8'h08, 32'h1234); rd(8'h08, v); chk("R2 restart reads 0", v, 32'h0);
        rd(8'h14, v); chk("R2 clear reads 0", v, 32'h0);
        for (int c = 0; c < 32; c++) begin
            wr(8'h0C, 32'hFFFFFFE0 | c);
            rd(8'h0C, v); chk("R2 ctrl rw", v, c);
        end
        wr(8'h0C, 0);

        // R3 unmapped / misaligned
        wr(8'h04, 32'h00000050);
        foreach (v[i]) begin end
        wr(8'h24, 32'hFFFFFFFF); wr(8'h05, 32'h11111111); wr(8'h86, 32'h22222222);
        rd(8'h24, v); chk("R3 unmapped read", v, 32'h0);
        rd(8'h05, v); chk("R3 misaligned read", v, 32'h0);
        rd(8'h84, v); chk("R3 high offset read", v, 32'h0);
        rd(8'h04, v); chk("R3 load untouched", v, 32'h50);
        rd(8'h0C, v); chk("R3 ctrl untouched", v, 32'h0);

        // R4 / R5 enable loads and counts down
        ticks(4);
        rd(8'h00, v); chk("R4 disabled reads load", v, 32'h50);
        wr(8'h0C, 32'h1);
        rd(8'h00, v); chk("R5 loaded on enable", v, 32'h50);
        for (int k = 1; k <= 6; k++) begin
            ticks(k);
            rd(8'h00, v); chk("R4 R5 live count", v, 32'h50 - (k * (k + 1)) / 2);
        end
        // now 0x50-21 = 59
        // R6 re-enable while running
        wr(8'h0C, 32'h1);
        rd(8'h00, v); chk("R6 no reload when running", v, 32'd59);
        wr(8'h0C, 32'h0);
        ticks(3);
        wr(8'h04, 32'd100);
        wr(8'h0C, 32'h1);
        rd(8'h00, v); chk("R5 restart from stopped", v, 32'd100);

        // R7 keyed restart
        ticks(7);
        wr(8'h08, 32'h00005AB8); rd(8'h00, v); chk("R7 wrong key", v, 32'd93);
        wr(8'h08, 32'h00015AB9); rd(8'h00, v); chk("R7 wrong upper bits", v, 32'd93);
        wr(8'h10, 32'h00005AB9); rd(8'h00, v); chk("R7 key to other reg", v, 32'd93);
        wr(8'h08, 32'h00005AB9); rd(8'h00, v); chk("R7 good key", v, 32'd100);

        // R8 expiry sweep over small loads
        for (int L = 0; L < 6; L++) begin
            wr(8'h0C, 0); wr(8'h14, 32'h2);
            wr(8'h04, L);
            wr(8'h0C, 32'h5);
            ticks((L > 1) ? L - 1 : 0);
            rd(8'h10, v); chk("R8 not yet expired", v, 32'h0);
            chk("R10 irq low before expiry", {31'b0, wd_irq}, 32'h0);
            ticks(1);
            rd(8'h10, v); chk("R8 expired", v, 32'h2);
            rd(8'h00, v); chk("R8 count zero", v, 32'h0);
            chk("R10 irq high", {31'b0, wd_irq}, 32'h1);
            // R9 clear semantics
            wr(8'h14, 32'hFFFFFFFD); rd(8'h10, v); chk("R9 zero bits keep", v, 32'h2);
            wr(8'h14, 32'h2); rd(8'h10, v); chk("R9 cleared", v, 32'h0);
            chk("R10 irq drops", {31'b0, wd_irq}, 32'h0);
            ticks(3);
            rd(8'h10, v); chk("R8 no re-expiry", v, 32'h0);
            rd(8'h00, v); chk("R8 holds zero", v, 32'h0);
        end

        // R10 irq gated by enable bit
        wr(8'h0C, 0); wr(8'h04, 1); wr(8'h0C, 32'h1); ticks(1);
        rd(8'h10, v); chk("R10 status set", v, 32'h2);
        chk("R10 irq masked", {31'b0, wd_irq}, 32'h0);
        wr(8'h0C, 32'h5);
        chk("R10 irq unmasked", {31'b0, wd_irq}, 32'h1);

        // R11 / R12 pulse widths across lengths and modes
        for (int len = 0; len < 5; len++) begin
            for (int m = 0; m < 8; m++) begin
                int rc, ec;
                logic [31:0] c;
                c = 32'h1 | (m << 1);
                wr(8'h0C, 0); wr(8'h14, 32'h2);
                wr(8'h18, len); wr(8'h04, 2);
                wr(8'h0C, c);
                ticks(1);
                chk("R11 no early pulse", {30'b0, wd_sysrst_req, wd_ext_pulse}, 32'h0);
                ticks(1);
                chk("R10 irq mode", {31'b0, wd_irq}, {31'b0, c[2]});
                rc = 0; ec = 0;
                for (int i = 0; i < 300; i++) begin
                    if (wd_sysrst_req) rc++;
                    if (wd_ext_pulse) ec++;
                    @(posedge clk); @(negedge clk);
                end
                chk("R11 reset pulse width", rc, c[1] ? len : 0);
                chk("R12 external pulse width", ec, c[3] ? len : 0);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule